// File: doc/BRIEF.md
# Dimmable Static Segment Display Driver

This block turns a 12-hour time reading into the individual segment lines of a static (non-multiplexed) 3½-digit display. It takes BCD hour and minute digits and a 1 Hz colon signal. It decodes each digit into its segments. The leading hour position has one combined line that shows "1". The tens-of-minutes position has one line shared by its top and bottom bars.

Every lit segment, including the colon, is then gated by a brightness pattern. That pattern comes from a free-running 4-bit phase counter, which steps once for each pulse on a fast time-base input. Two dimmer lines pick one of four duty ratios. A low level on the blanking input switches every segment off.

All segment outputs are active high: a 1 means the segment is lit. The outputs are combinational from the inputs and the phase counter, so a digit change shows up in the same cycle.

Top module: `dim_seg_drv`

## Requirements
- R1: The dimmer lines select the duty ratio. {dim_a_i, dim_b_i} = 00 gives full duty, 10 gives 1/4, 01 gives 1/8 and 11 gives 1/16. Over any 16 consecutive counter phases, a lit segment is on for 16, 4, 2 or 1 phases respectively.
- R2: The phase counter resets to 0. It advances by one for each clock with pwm_tick_i high, wraps from 15 to 0, and holds when pwm_tick_i is low. For duty 1/N, segments are enabled only in phases whose value is a multiple of N, so phase 0 is enabled in every mode.
- R3: While blank_n_i is low, every output (lead line, all digit segments and the colon) is 0, whatever the other inputs are.
- R4: hr_lead_o lights (when enabled) only when hr_tens_i is 1, for hours 10 to 12. A hour-tens value of 0 leaves it dark, which suppresses the leading zero.
- R5: hr_ones_o and mo_o use seven-segment bits {g,f,e,d,c,b,a}, with a in bit 0. Digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex), so 6 includes a and 9 includes d. Codes 10 to 15 are dark.
- R6: mt_o carries {g,f,e,c,b,ad}, with the shared a/d line in bit 0. The ad line lights for minute-tens 0, 2, 3 and 5 and is dark for 1 and 4. The other bits follow the seven-segment shapes of the digit. Values 6 and 7 are dark.
- R7: colon_o follows colon_i, gated by the same enable as the digit segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_tick_i | input | 1 | Time-base pulse; advances the phase counter |
| dim_a_i | input | 1 | First dimmer select line |
| dim_b_i | input | 1 | Second dimmer select line |
| blank_n_i | input | 1 | Low switches every segment off |
| colon_i | input | 1 | 1 Hz colon signal |
| hr_tens_i | input | 1 | Hour tens digit (0 or 1) |
| hr_ones_i | input | 4 | Hour ones digit, BCD |
| mt_i | input | 3 | Minute tens digit, 0 to 5 |
| mo_i | input | 4 | Minute ones digit, BCD |
| hr_lead_o | output | 1 | Combined b/c line of the leading hour digit |
| hr_ones_o | output | 7 | Hour ones segments {g,f,e,d,c,b,a} |
| mt_o | output | 6 | Minute tens segments {g,f,e,c,b,ad} |
| mo_o | output | 7 | Minute ones segments {g,f,e,d,c,b,a} |
| colon_o | output | 1 | Colon segment |

## Verification
Every digit value 0 to 15 is swept on both seven-segment positions at full duty. Minute-tens runs through 0 to 7, which separates the shared a/d line from the real b, c, e, f and g shapes and confirms that the out-of-range values stay dark. For each of the four dimmer codes, the counter is stepped through a full 16-phase cycle and the lit phases are counted and matched phase by phase. This tells a duty-mapping error apart from a wrong phase selection or a counter that does not wrap. Blanking is applied with all segments and the colon requested, and the hour-tens toggle covers leading-zero suppression.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int PH_W = 4;
  localparam int SEG_W = 7;
  localparam int MT_W = 6;

  typedef logic [SEG_W-1:0] seg7_t;
  typedef logic [PH_W-1:0] phase_t;

  // Seven-segment shape, bit order {g,f,e,d,c,b,a}; non-decimal codes dark.
  function automatic seg7_t shape_of(input logic [3:0] d);
    case (d)
      4'd0: shape_of = 7'h3F;
      4'd1: shape_of = 7'h06;
      4'd2: shape_of = 7'h5B;
      4'd3: shape_of = 7'h4F;
      4'd4: shape_of = 7'h66;
      4'd5: shape_of = 7'h6D;
      4'd6: shape_of = 7'h7D;
      4'd7: shape_of = 7'h07;
      4'd8: shape_of = 7'h7F;
      4'd9: shape_of = 7'h6F;
      default: shape_of = 7'h00;
    endcase
  endfunction

  // Phase bits that must be zero for a segment to be enabled.
  function automatic phase_t duty_mask(input logic sel_a, input logic sel_b);
    case ({sel_a, sel_b})
      2'b11: duty_mask = 4'hF;
      2'b01: duty_mask = 4'h7;
      2'b10: duty_mask = 4'h3;
      default: duty_mask = 4'h0;
    endcase
  endfunction

  // Fold a full shape onto the reduced minute-tens lines {g,f,e,c,b,ad}.
  function automatic logic [MT_W-1:0] fold_mt(input seg7_t s);
    fold_mt = {s[6], s[5], s[4], s[2], s[1], s[0]};
  endfunction
endpackage

// File: rtl/dsd_phase_gen.sv
module dsd_phase_gen
  import dsd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   sel_a,
  input  logic   sel_b,
  input  logic   blank_n,
  output phase_t phase,
  output logic   gate_on
);
  phase_t mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (tick) phase <= phase + 1'b1;
  end

  assign mask    = duty_mask(sel_a, sel_b);
  assign gate_on = blank_n && ((phase & mask) == '0);

  // R2: counter steps by one per tick, wrapping naturally
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase == $past(phase) + 1'b1);
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));
  // R1: full duty is never gated off while unblanked
  a_r1_full_on: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !sel_a && !sel_b) |-> gate_on);
  // R2: phase 0 enabled in every mode
  a_r2_phase0_on: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && phase == '0) |-> gate_on);
endmodule

// File: rtl/dsd_digit.sv
module dsd_digit
  import dsd_pkg::*;
(
  input  logic [3:0] digit,
  input  logic       gate_on,
  output seg7_t      seg
);
  assign seg = gate_on ? shape_of(digit) : '0;
endmodule

// File: rtl/dim_seg_drv.sv
module dim_seg_drv
  import dsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_tick_i,
  input  logic       dim_a_i,
  input  logic       dim_b_i,
  input  logic       blank_n_i,
  input  logic       colon_i,
  input  logic       hr_tens_i,
  input  logic [3:0] hr_ones_i,
  input  logic [2:0] mt_i,
  input  logic [3:0] mo_i,
  output logic       hr_lead_o,
  output logic [6:0] hr_ones_o,
  output logic [5:0] mt_o,
  output logic [6:0] mo_o,
  output logic       colon_o
);
  localparam int N_DIG = 3;

  phase_t      phase;
  logic        gate_on;
  logic [3:0]  dig_in  [N_DIG];
  seg7_t       dig_seg [N_DIG];
  logic [3:0]  mt_ext;

  dsd_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (pwm_tick_i),
    .sel_a   (dim_a_i),
    .sel_b   (dim_b_i),
    .blank_n (blank_n_i),
    .phase   (phase),
    .gate_on (gate_on)
  );

  // Minute tens limited to 0..5; larger values map to a dark code.
  assign mt_ext    = (mt_i <= 3'd5) ? {1'b0, mt_i} : 4'hF;
  assign dig_in[0] = hr_ones_i;
  assign dig_in[1] = mt_ext;
  assign dig_in[2] = mo_i;

  for (genvar gi = 0; gi < N_DIG; gi++) begin : g_dig
    dsd_digit u_dig (
      .digit   (dig_in[gi]),
      .gate_on (gate_on),
      .seg     (dig_seg[gi])
    );
  end

  assign hr_lead_o = gate_on & hr_tens_i;
  assign hr_ones_o = dig_seg[0];
  assign mt_o      = fold_mt(dig_seg[1]);
  assign mo_o      = dig_seg[2];
  assign colon_o   = gate_on & colon_i;

  // R3: blanking darkens everything
  a_r3_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n_i |-> (!hr_lead_o && hr_ones_o == '0 && mt_o == '0 &&
                    mo_o == '0 && !colon_o));
  // R4: leading digit dark when hour tens is zero
  a_r4_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hr_tens_i |-> !hr_lead_o);
  // R6: shared a/d line dark for minute tens 1 and 4
  a_r6_ad_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_i == 3'd1 || mt_i == 3'd4) |-> !mt_o[0]);
  // R7: colon never lit without the colon input
  a_r7_colon: assert property (@(posedge clk) disable iff (!rst_n)
    !colon_i |-> !colon_o);
  // R1: segments and colon share one enable
  a_r1_common_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (colon_i && hr_ones_i == 4'd8) |-> (colon_o == hr_ones_o[0]));
endmodule

// File: tb/test_dim_seg_drv.sv
`timescale 1ns/1ps
module test_dim_seg_drv;
  logic clk = 0, rst_n = 0, pwm_tick_i = 0, dim_a_i = 0, dim_b_i = 0;
  logic blank_n_i = 0, colon_i = 0, hr_tens_i = 0;
  logic [3:0] hr_ones_i = 0, mo_i = 0;
  logic [2:0] mt_i = 0;
  logic hr_lead_o, colon_o;
  logic [6:0] hr_ones_o, mo_o;
  logic [5:0] mt_o;
  int total = 0, bad = 0, ph = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dim_seg_drv i_dim_seg_drv (.*);

  function automatic logic [6:0] exp7(input int d);
    logic a, b, c, dd, e, f, g;
    if (d > 9) return 7'h00;
    a  = !(d == 1 || d == 4);
    b  = !(d == 5 || d == 6);
    c  = (d != 2);
    dd = (d inside {0, 2, 3, 5, 6, 8, 9});
    e  = (d inside {0, 2, 6, 8});
    f  = (d inside {0, 4, 5, 6, 8, 9});
    g  = (d inside {2, 3, 4, 5, 6, 8, 9});
    return {g, f, e, dd, c, b, a};
  endfunction

  function automatic logic [5:0] expmt(input int d);
    logic [6:0] s;
    s = (d > 5) ? 7'h00 : exp7(d);
    return {s[6], s[5], s[4], s[2], s[1], s[0]};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); pwm_tick_i = 1;
    @(negedge clk); pwm_tick_i = 0;
    ph = (ph + 1) % 16;
    #1;
  endtask

  task automatic settle(); @(negedge clk); #1; endtask

  task automatic t_reset();
    rst_n = 0; blank_n_i = 1; dim_a_i = 1; dim_b_i = 1; hr_ones_i = 8; ph = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; settle();
    chk("R2", "phase0 lit after reset", hr_ones_o, 7'h7F);
    step();
    chk("R2", "phase1 dark at 1/16", hr_ones_o, 0);
    @(negedge clk); #1;
    chk("R2", "no tick holds phase", hr_ones_o, 0);
  endtask

  task automatic t_digits();
    dim_a_i = 0; dim_b_i = 0; blank_n_i = 1; settle();
    for (int d = 0; d < 16; d++) begin
      hr_ones_i = d[3:0]; mo_i = 4'(15 - d); #1;
      chk("R5", $sformatf("hour ones %0d", d), hr_ones_o, exp7(d));
      chk("R5", $sformatf("minute ones %0d", 15 - d), mo_o, exp7(15 - d));
    end
    for (int d = 0; d < 8; d++) begin
      mt_i = d[2:0]; #1;
      chk("R6", $sformatf("minute tens %0d", d), mt_o, expmt(d));
    end
  endtask

  task automatic t_lead_colon();
    hr_tens_i = 0; colon_i = 1; #1;
    chk("R4", "lead dark for tens 0", hr_lead_o, 0);
    chk("R7", "colon lit", colon_o, 1);
    hr_tens_i = 1; colon_i = 0; #1;
    chk("R4", "lead lit for tens 1", hr_lead_o, 1);
    chk("R7", "colon dark", colon_o, 0);
  endtask

  task automatic t_duty(input logic a, input logic b, input int n);
    int lit = 0;
    dim_a_i = a; dim_b_i = b; hr_ones_i = 8; colon_i = 1; hr_tens_i = 1; #1;
    for (int i = 0; i < 16; i++) begin
      logic on;
      on = (ph % n) == 0;
      if (hr_ones_o == 7'h7F) lit++;
      chk("R2", $sformatf("phase %0d mode %0d%0d", ph, a, b), hr_ones_o, on ? 7'h7F : 0);
      chk("R7", $sformatf("colon phase %0d", ph), colon_o, on);
      step();
    end
    chk("R1", $sformatf("lit count mode %0d%0d", a, b), lit, 16 / n);
  endtask

  task automatic t_blank();
    dim_a_i = 0; dim_b_i = 0; colon_i = 1; hr_tens_i = 1; hr_ones_i = 8;
    mo_i = 8; mt_i = 0; blank_n_i = 0; #1;
    chk("R3", "blank all dark",
        {hr_lead_o, hr_ones_o, mt_o, mo_o, colon_o}, 0);
    blank_n_i = 1; #1;
    chk("R3", "unblank lit", hr_ones_o, 7'h7F);
  endtask

  initial begin
    t_reset();
    t_digits();
    t_lead_colon();
    t_duty(0, 0, 1);
    t_duty(1, 0, 4);
    t_duty(0, 1, 8);
    t_duty(1, 1, 16);
    t_blank();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule